// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block joins two eight-line interrupt controller cores into one sixteen-line source. Request lines 0 to 7 belong to the primary core and lines 8 to 15 to the secondary core. Whenever the secondary core holds a request it could deliver, it marks line 2 of the primary core as pending. The primary core drives a single interrupt line toward the processor.

When the processor raises the acknowledge strobe, the unit resolves the winner. It first resolves the primary core. If the primary winner is line 2, it resolves the secondary core as well. It then returns an 8-bit vector number. The upper five bits of the vector come from a per-core base and the lower three bits from the winning line. The value 7 is substituted when no real winner exists, which marks a spurious interrupt.

Each core has a trigger-mode register, set through a write port, that selects edge or level sensing per line. Only certain bits of each register can be written. The unit also has per-line masks and a non-specific end-of-interrupt command for each core.

Top module: `cascade_vector_unit`

## Requirements
- R1: A rising edge on an unmasked edge-sensed line is latched as pending. For a primary line, cpuIrq goes high after the second rising clock edge that follows the input change. For a secondary line it goes high after the third.
- R2: Acknowledging an edge-sensed line clears its pending state. A level-sensed line stays pending while its input is high, even after acknowledge, and stops being pending when its input goes low.
- R3: A line whose mask bit is 1 is never delivered. Clearing the mask bit makes a latched request deliverable.
- R4: The lowest-numbered pending line wins within a core. A line is delivered only if its number is lower than every line currently in service in that core.
- R5: While the secondary core has a deliverable request, line 2 of the primary core is latched pending. This happens even though that line is never level-sensed.
- R6: If the primary winner is line 2 and the secondary core has a winner, the vector is {slaveBase, secondary winner}. Both cores then mark their winners as in service.
- R7: If the primary winner is line 2 but the secondary core has no winner, the vector is {slaveBase, 3'd7}.
- R8: If the primary core has no winner at acknowledge, the vector is {masterBase, 3'd7}, and no in-service state changes.
- R9: In every other case the vector is {masterBase, primary winner}. Bits 7:3 of the vector always hold a 5-bit base, so its low three bits come only from the line number.
- R10: Writing trigData with trigWr high stores it into the primary trigger register (trigWrSlave=0) or the secondary one (trigWrSlave=1). The stored value is ANDed with 8'hF8 (primary) or 8'hDE (secondary), so bits outside the mask always read as 0. A stored 1 means level-sensed.
- R11: vectorValid is high for exactly the cycle after the edge that samples ackStrobe, and vector is valid in that cycle. cpuIrq reflects the post-acknowledge state one cycle later.
- R12: An end-of-interrupt strobe clears the lowest-numbered in-service line of the selected core (eoiSlave=1 selects the secondary core).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | 16 | Request inputs, 0-7 primary, 8-15 secondary |
| ackStrobe | input | 1 | Processor acknowledge strobe |
| masterBase | input | 5 | Upper vector bits for the primary core |
| slaveBase | input | 5 | Upper vector bits for the secondary core |
| masterMask | input | 8 | Per-line mask, primary core |
| slaveMask | input | 8 | Per-line mask, secondary core |
| eoiStrobe | input | 1 | Non-specific end of interrupt |
| eoiSlave | input | 1 | End-of-interrupt target select |
| trigWr | input | 1 | Trigger register write strobe |
| trigWrSlave | input | 1 | Trigger register target select |
| trigData | input | 8 | Trigger register write data |
| cpuIrq | output | 1 | Interrupt line to the processor |
| vector | output | 8 | Vector number |
| vectorValid | output | 1 | Vector qualifier |
| masterTrig | output | 8 | Primary trigger register readback |
| slaveTrig | output | 8 | Secondary trigger register readback |

## Verification
A pending request is latched at the first clock edge after the input changes. The cascade into primary line 2 takes one more edge, and cpuIrq is registered behind that. The primary delay is therefore two edges and the secondary delay three. The vector appears one edge after the acknowledge is sampled, and cpuIrq reflects the new in-service state one edge after that. Every bench task changes inputs just after a falling edge and samples at a later falling edge. The number of intervening edges is counted from the register chain above. Where the timing matters, the bench also checks that the output has not yet changed one edge early.

// File: rtl/cvu_pkg.sv
package cvu_pkg;
  localparam int CASCADE_LINE = 2;

  typedef struct packed {
    logic ackMaster;
    logic ackSlave;
    logic cascadeSet;
    logic eoiMaster;
    logic eoiSlave;
    logic trigWrMaster;
    logic trigWrSlave;
    logic issueVector;
  } cvuStrobes_t;
endpackage

// File: rtl/pic_core.sv
module pic_core #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] TRIG_MASK = '1,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] maskIn,
  input  logic             trigWr,
  input  logic [LINES-1:0] trigData,
  input  logic             ackDo,
  input  logic [IW-1:0]    ackIdx,
  input  logic             eoiDo,
  input  logic [LINES-1:0] forceSet,
  output logic             winValid,
  output logic [IW-1:0]    winIdx,
  output logic [LINES-1:0] irrOut,
  output logic [LINES-1:0] trigOut
);
  logic [LINES-1:0] trig, irr, lastLvl, isr;
  logic [LINES-1:0] pendMasked, ackVec, eoiVec;
  logic [IW-1:0] isrIdx;
  logic pendAny, isrAny;

  always_comb begin
    pendMasked = irr & ~maskIn;
    pendAny = |pendMasked;
    isrAny = |isr;
    winIdx = '0;
    isrIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pendMasked[i]) winIdx = IW'(i);
      if (isr[i]) isrIdx = IW'(i);
    end
    winValid = pendAny && (!isrAny || (winIdx < isrIdx));
    ackVec = '0;
    eoiVec = '0;
    if (ackDo) ackVec[ackIdx] = 1'b1;
    if (eoiDo && isrAny) eoiVec[isrIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trig <= '0;
      irr <= '0;
      lastLvl <= '0;
      isr <= '0;
    end else begin
      if (trigWr) trig <= trigData & TRIG_MASK;
      lastLvl <= lineIn;
      for (int i = 0; i < LINES; i++) begin
        if (forceSet[i]) irr[i] <= 1'b1;
        else if (trig[i]) irr[i] <= lineIn[i];
        else irr[i] <= (irr[i] | (lineIn[i] & ~lastLvl[i])) & ~ackVec[i];
      end
      isr <= (isr & ~eoiVec) | ackVec;
    end
  end

  assign irrOut = irr;
  assign trigOut = trig;
endmodule

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
  import cvu_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          ackStrobe,
  input  logic          masterWinValid,
  input  logic [IW-1:0] masterWinIdx,
  input  logic          slaveWinValid,
  input  logic          eoiStrobe,
  input  logic          eoiSlave,
  input  logic          trigWr,
  input  logic          trigWrSlave,
  output cvuStrobes_t   strobes
);
  always_comb begin
    strobes.issueVector  = ackStrobe;
    strobes.ackMaster    = ackStrobe && masterWinValid;
    strobes.ackSlave     = strobes.ackMaster && (masterWinIdx == IW'(CASCADE_LINE))
                           && slaveWinValid;
    strobes.cascadeSet   = slaveWinValid && !strobes.ackSlave;
    strobes.eoiMaster    = eoiStrobe && !eoiSlave;
    strobes.eoiSlave     = eoiStrobe && eoiSlave;
    strobes.trigWrMaster = trigWr && !trigWrSlave;
    strobes.trigWrSlave  = trigWr && trigWrSlave;
  end
endmodule

// File: rtl/vector_path.sv
module vector_path
  import cvu_pkg::*;
#(
  parameter int IW = 3,
  parameter int BASE_W = 5,
  localparam int VW = BASE_W + IW
) (
  input  logic              clk,
  input  logic              rstN,
  input  cvuStrobes_t       strobes,
  input  logic [BASE_W-1:0] masterBase,
  input  logic [BASE_W-1:0] slaveBase,
  input  logic              masterWinValid,
  input  logic [IW-1:0]     masterWinIdx,
  input  logic              slaveWinValid,
  input  logic [IW-1:0]     slaveWinIdx,
  output logic [VW-1:0]     vector,
  output logic              vectorValid,
  output logic              cpuIrq
);
  localparam logic [IW-1:0] SPUR = '1;
  logic [VW-1:0] vecNext;

  always_comb begin
    if (!masterWinValid) vecNext = {masterBase, SPUR};
    else if (masterWinIdx != IW'(CASCADE_LINE)) vecNext = {masterBase, masterWinIdx};
    else if (slaveWinValid) vecNext = {slaveBase, slaveWinIdx};
    else vecNext = {slaveBase, SPUR};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vector <= '0;
      vectorValid <= 1'b0;
      cpuIrq <= 1'b0;
    end else begin
      vectorValid <= strobes.issueVector;
      if (strobes.issueVector) vector <= vecNext;
      cpuIrq <= masterWinValid;
    end
  end
endmodule

// File: rtl/cascade_vector_unit.sv
module cascade_vector_unit
  import cvu_pkg::*;
#(
  parameter int LINES = 8,
  parameter int BASE_W = 5,
  parameter logic [LINES-1:0] MASTER_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLAVE_TRIG_MASK = 8'hDE,
  localparam int IW = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*LINES-1:0]   reqLines,
  input  logic                 ackStrobe,
  input  logic [BASE_W-1:0]    masterBase,
  input  logic [BASE_W-1:0]    slaveBase,
  input  logic [LINES-1:0]     masterMask,
  input  logic [LINES-1:0]     slaveMask,
  input  logic                 eoiStrobe,
  input  logic                 eoiSlave,
  input  logic                 trigWr,
  input  logic                 trigWrSlave,
  input  logic [LINES-1:0]     trigData,
  output logic                 cpuIrq,
  output logic [BASE_W+IW-1:0] vector,
  output logic                 vectorValid,
  output logic [LINES-1:0]     masterTrig,
  output logic [LINES-1:0]     slaveTrig
);
  cvuStrobes_t strobes;
  logic masterWinValid, slaveWinValid;
  logic [IW-1:0] masterWinIdx, slaveWinIdx;
  logic [LINES-1:0] masterIrr, slaveIrr, cascadeVec;

  always_comb begin
    cascadeVec = '0;
    cascadeVec[CASCADE_LINE] = strobes.cascadeSet;
  end

  pic_core #(.LINES(LINES), .TRIG_MASK(MASTER_TRIG_MASK)) uMaster (
    .clk(clk), .rstN(rstN), .lineIn(reqLines[LINES-1:0]), .maskIn(masterMask),
    .trigWr(strobes.trigWrMaster), .trigData(trigData),
    .ackDo(strobes.ackMaster), .ackIdx(masterWinIdx), .eoiDo(strobes.eoiMaster),
    .forceSet(cascadeVec), .winValid(masterWinValid), .winIdx(masterWinIdx),
    .irrOut(masterIrr), .trigOut(masterTrig));

  pic_core #(.LINES(LINES), .TRIG_MASK(SLAVE_TRIG_MASK)) uSlave (
    .clk(clk), .rstN(rstN), .lineIn(reqLines[2*LINES-1:LINES]), .maskIn(slaveMask),
    .trigWr(strobes.trigWrSlave), .trigData(trigData),
    .ackDo(strobes.ackSlave), .ackIdx(slaveWinIdx), .eoiDo(strobes.eoiSlave),
    .forceSet('0), .winValid(slaveWinValid), .winIdx(slaveWinIdx),
    .irrOut(slaveIrr), .trigOut(slaveTrig));

  cascade_ctrl #(.IW(IW)) uCtrl (
    .ackStrobe(ackStrobe), .masterWinValid(masterWinValid), .masterWinIdx(masterWinIdx),
    .slaveWinValid(slaveWinValid), .eoiStrobe(eoiStrobe), .eoiSlave(eoiSlave),
    .trigWr(trigWr), .trigWrSlave(trigWrSlave), .strobes(strobes));

  vector_path #(.IW(IW), .BASE_W(BASE_W)) uVec (
    .clk(clk), .rstN(rstN), .strobes(strobes), .masterBase(masterBase),
    .slaveBase(slaveBase), .masterWinValid(masterWinValid), .masterWinIdx(masterWinIdx),
    .slaveWinValid(slaveWinValid), .slaveWinIdx(slaveWinIdx), .vector(vector),
    .vectorValid(vectorValid), .cpuIrq(cpuIrq));
endmodule

// File: rtl/cvu_checker.sv
module cvu_checker #(
  parameter int LINES = 8,
  parameter int BASE_W = 5,
  parameter logic [LINES-1:0] MASTER_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLAVE_TRIG_MASK = 8'hDE,
  localparam int IW = $clog2(LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ackStrobe,
  input logic [BASE_W-1:0]    masterBase,
  input logic [BASE_W-1:0]    slaveBase,
  input logic [BASE_W+IW-1:0] vector,
  input logic                 vectorValid,
  input logic [LINES-1:0]     masterTrig,
  input logic [LINES-1:0]     slaveTrig,
  input logic                 slaveWin,
  input logic                 masterWin,
  input logic [LINES-1:0]     masterIrr
);
  assert_vec_follows_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> vectorValid);
  assert_vec_needs_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    vectorValid |-> $past(ackStrobe));
  assert_vec_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    vectorValid |-> (vector[BASE_W+IW-1:IW] == $past(masterBase) ||
                     vector[BASE_W+IW-1:IW] == $past(slaveBase)));
  assert_spurious_master_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !masterWin) |=> (vector == {$past(masterBase), {IW{1'b1}}}));
  assert_cascade_mark_R5: assert property (@(posedge clk) disable iff (!rstN)
    (slaveWin && !ackStrobe) |=> masterIrr[2]);
  assert_trig_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((masterTrig & ~MASTER_TRIG_MASK) == '0) && ((slaveTrig & ~SLAVE_TRIG_MASK) == '0));
endmodule

bind cascade_vector_unit cvu_checker #(
  .LINES(LINES), .BASE_W(BASE_W),
  .MASTER_TRIG_MASK(MASTER_TRIG_MASK), .SLAVE_TRIG_MASK(SLAVE_TRIG_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .masterBase(masterBase),
  .slaveBase(slaveBase), .vector(vector), .vectorValid(vectorValid),
  .masterTrig(masterTrig), .slaveTrig(slaveTrig), .slaveWin(slaveWinValid),
  .masterWin(masterWinValid), .masterIrr(masterIrr));

// File: tb/tb_cascade_vector_unit.sv
module tb_cascade_vector_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] reqLines = '0;
  logic ackStrobe = 1'b0;
  logic [4:0] masterBase = 5'h04;
  logic [4:0] slaveBase = 5'h0E;
  logic [7:0] masterMask = '0;
  logic [7:0] slaveMask = '0;
  logic eoiStrobe = 1'b0;
  logic eoiSlave = 1'b0;
  logic trigWr = 1'b0;
  logic trigWrSlave = 1'b0;
  logic [7:0] trigData = '0;
  logic cpuIrq, vectorValid;
  logic [7:0] vector, masterTrig, slaveTrig;
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cascade_vector_unit dut (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .ackStrobe(ackStrobe),
    .masterBase(masterBase), .slaveBase(slaveBase), .masterMask(masterMask),
    .slaveMask(slaveMask), .eoiStrobe(eoiStrobe), .eoiSlave(eoiSlave),
    .trigWr(trigWr), .trigWrSlave(trigWrSlave), .trigData(trigData),
    .cpuIrq(cpuIrq), .vector(vector), .vectorValid(vectorValid),
    .masterTrig(masterTrig), .slaveTrig(slaveTrig));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // Acknowledge, check vector and single-cycle valid, then cpuIrq re-evaluation
  task automatic doAck(input string req, input logic [7:0] expVec, input logic expIrqAfter);
    ackStrobe = 1'b1;
    tick(1);
    ackStrobe = 1'b0;
    check({req, " vectorValid"}, 16'(vectorValid), 16'd1);
    check({req, " vector"}, 16'(vector), 16'(expVec));
    tick(1);
    check("R11 valid pulse width", 16'(vectorValid), 16'd0);
    check({req, " cpuIrq after ack"}, 16'(cpuIrq), 16'(expIrqAfter));
  endtask

  task automatic doEoi(input logic sel);
    eoiStrobe = 1'b1;
    eoiSlave = sel;
    tick(1);
    eoiStrobe = 1'b0;
    eoiSlave = 1'b0;
  endtask

  task automatic writeTrig(input logic sel, input logic [7:0] val);
    trigWr = 1'b1;
    trigWrSlave = sel;
    trigData = val;
    tick(1);
    trigWr = 1'b0;
  endtask

  task automatic testReset();
    check("R11 reset cpuIrq", 16'(cpuIrq), 16'd0);
    check("R11 reset vectorValid", 16'(vectorValid), 16'd0);
    check("R10 reset masterTrig", 16'(masterTrig), 16'd0);
  endtask

  task automatic testTrigMask_R10();
    writeTrig(1'b0, 8'hFF);
    check("R10 master mask", 16'(masterTrig), 16'h00F8);
    writeTrig(1'b1, 8'hFF);
    check("R10 slave mask", 16'(slaveTrig), 16'h00DE);
    writeTrig(1'b1, 8'h21);
    check("R10 slave masked bits", 16'(slaveTrig), 16'h0000);
    writeTrig(1'b0, 8'h00);
  endtask

  task automatic testEdgeMaster_R1();
    reqLines[5] = 1'b1;
    tick(1);
    check("R1 not yet", 16'(cpuIrq), 16'd0);
    tick(1);
    check("R1 primary edge", 16'(cpuIrq), 16'd1);
    doAck("R9 primary line 5", {5'h04, 3'd5}, 1'b0);
    doEoi(1'b0);
    tick(2);
    check("R2 edge cleared by ack", 16'(cpuIrq), 16'd0);
    reqLines[5] = 1'b0;
    tick(1);
  endtask

  task automatic testPriority_R4();
    reqLines[6] = 1'b1;
    reqLines[4] = 1'b1;
    tick(2);
    doAck("R4 lowest wins", {5'h04, 3'd4}, 1'b0);
    doEoi(1'b0);
    tick(1);
    check("R4 next after eoi", 16'(cpuIrq), 16'd1);
    doAck("R4 second", {5'h04, 3'd6}, 1'b0);
    doEoi(1'b0);
    reqLines[6] = 1'b0;
    reqLines[4] = 1'b0;
    tick(1);
  endtask

  task automatic testMask_R3();
    masterMask[1] = 1'b1;
    reqLines[1] = 1'b1;
    tick(3);
    check("R3 masked", 16'(cpuIrq), 16'd0);
    masterMask[1] = 1'b0;
    tick(1);
    check("R3 unmasked", 16'(cpuIrq), 16'd1);
    doAck("R3 vector", {5'h04, 3'd1}, 1'b0);
    doEoi(1'b0);
    reqLines[1] = 1'b0;
    tick(1);
  endtask

  task automatic testCascade_R6();
    reqLines[11] = 1'b1;
    tick(1);
    check("R5 edge 1", 16'(cpuIrq), 16'd0);
    tick(1);
    check("R5 edge 2", 16'(cpuIrq), 16'd0);
    tick(1);
    check("R5 R1 secondary cpuIrq", 16'(cpuIrq), 16'd1);
    doAck("R6 cascade vector", {5'h0E, 3'd3}, 1'b0);
    doEoi(1'b1);
    doEoi(1'b0);
    tick(2);
    check("R6 both acked", 16'(cpuIrq), 16'd0);
    reqLines[11] = 1'b0;
    tick(1);
  endtask

  task automatic testSpuriousSlave_R7();
    reqLines[2] = 1'b1;
    tick(2);
    check("R7 line 2 pending", 16'(cpuIrq), 16'd1);
    doAck("R7 spurious secondary", {5'h0E, 3'd7}, 1'b0);
    doEoi(1'b0);
    reqLines[2] = 1'b0;
    tick(1);
  endtask

  task automatic testSpuriousMaster_R8();
    doAck("R8 spurious primary", {5'h04, 3'd7}, 1'b0);
    masterBase = 5'h1F;
    doAck("R8 R9 other base", {5'h1F, 3'd7}, 1'b0);
    masterBase = 5'h04;
  endtask

  task automatic testLevel_R2();
    writeTrig(1'b0, 8'h08);
    reqLines[3] = 1'b1;
    tick(2);
    check("R2 level pending", 16'(cpuIrq), 16'd1);
    doAck("R2 level vector", {5'h04, 3'd3}, 1'b0);
    doEoi(1'b0);
    tick(1);
    check("R2 level still pending", 16'(cpuIrq), 16'd1);
    reqLines[3] = 1'b0;
    tick(2);
    check("R2 level dropped", 16'(cpuIrq), 16'd0);
    writeTrig(1'b0, 8'h00);
  endtask

  task automatic testNested_R12();
    reqLines[5] = 1'b1;
    tick(2);
    doAck("R12 first", {5'h04, 3'd5}, 1'b0);
    reqLines[1] = 1'b1;
    tick(2);
    check("R4 higher preempts", 16'(cpuIrq), 16'd1);
    doAck("R12 nested", {5'h04, 3'd1}, 1'b0);
    doEoi(1'b0);
    reqLines[6] = 1'b1;
    tick(2);
    check("R12 line 5 still in service", 16'(cpuIrq), 16'd0);
    doEoi(1'b0);
    tick(1);
    check("R12 second eoi releases", 16'(cpuIrq), 16'd1);
    doAck("R12 line 6", {5'h04, 3'd6}, 1'b0);
    doEoi(1'b0);
    reqLines = '0;
    tick(1);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testTrigMask_R10();
    testEdgeMaster_R1();
    testPriority_R4();
    testMask_R3();
    testCascade_R6();
    testSpuriousSlave_R7();
    testSpuriousMaster_R8();
    testLevel_R2();
    testNested_R12();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end
endmodule